// File: doc/BRIEF.md
# Windowed Picture Pixel Renderer

This block paints a small stored picture into a 640x480 display raster that runs at 60 Hz (800 clocks per line, 525 lines per frame, a pixel clock near 25.2 MHz). A separate timing generator supplies the current active-area column and row and a data-enable. The renderer answers with a 24-bit colour and an enable that is delayed to match that colour.

The picture is 128 pixels wide and 78 pixels high. Its pixels sit in an internal memory of 9984 16-bit words, one pixel per word, in RGB565 format. When the current pixel lies inside the picture's window, the renderer computes a row-major address and reads the word in one clock. It then widens each colour field to 8 bits. Active pixels outside the window show a fixed background colour, and blanked pixels show black.

The window's placement is set by two parameters, which are checked at elaboration. A plain write port loads the picture, so the memory needs no initial contents.

Top module: `img_window_render`

## Requirements
- R1: While reset is asserted, `rgb_out` is 24'h000000 and `de_out` is 0.
- R2: `de_out` equals the value `pix_de` had at the previous rising clock edge.
- R3: When `pix_de` is 0 at an edge, `rgb_out` after that edge is 24'h000000, whatever the column and row are.
- R4: When `pix_de` is 1 and the pixel is outside the window, `rgb_out` after that edge equals the parameter `BG_RGB` (default 24'h203040).
- R5: The window covers columns X_OFF to X_OFF+127 and rows Y_OFF to Y_OFF+77, with both ends included (default X_OFF=256, Y_OFF=200).
- R6: Inside the window, the pixel shown is memory word (row - Y_OFF) * 128 + (col - X_OFF). The memory is 16 bits wide and 9984 words deep.
- R7: Each memory word is RGB565, with red in bits [15:11], green in bits [10:5] and blue in bits [4:0]. The output is {R, G, B} with 8 bits each: red8 = {r5, r5[4:2]}, green8 = {g6, g6[5:4]} and blue8 = {b5, b5[4:2]}.
- R8: The colour for inputs sampled at an edge appears right after that edge, aligned with `de_out`. Back-to-back pixels follow each other with one clock of latency.
- R9: When `wr_en` is 1 and `wr_addr` < 9984, `wr_data` is stored at `wr_addr`. Reads in later cycles return the new word.
- R10: A write with `wr_addr` of 9984 or above changes no stored word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_de | input | 1 | Active-area enable from the timing generator |
| pix_col | input | 10 | Active-area column, 0 to 639 |
| pix_row | input | 9 | Active-area row, 0 to 479 |
| wr_en | input | 1 | Picture memory write strobe |
| wr_addr | input | 14 | Picture memory word address |
| wr_data | input | 16 | RGB565 word to store |
| rgb_out | output | 24 | Colour output, {red, green, blue} |
| de_out | output | 1 | Enable aligned with `rgb_out` |

## Verification
The memory is first loaded with a distinct word at every address, so a wrong address computation shows up as a wrong colour. Pixels at all four window corners and one step outside each edge separate off-by-one errors in the window bounds from errors in the row-major address. Pure red, green, blue, black, white and mid-grey words separate errors in the bit fields from errors in the low-bit replication. A stream of consecutive pixels that crosses the window edge, blanked probes inside the window, and an out-of-range write followed by read-back of the end words confirm the latency alignment, the blanking and the write guard.

// File: rtl/img_window_render.sv
module img_window_render #(
  parameter int H_ACTIVE = 640,
  parameter int V_ACTIVE = 480,
  parameter int IMG_W    = 128,
  parameter int IMG_H    = 78,
  parameter int X_OFF    = 256,
  parameter int Y_OFF    = 200,
  parameter logic [23:0] BG_RGB = 24'h203040
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pix_de,
  input  logic [9:0]  pix_col,
  input  logic [8:0]  pix_row,
  input  logic        wr_en,
  input  logic [13:0] wr_addr,
  input  logic [15:0] wr_data,
  output logic [23:0] rgb_out,
  output logic        de_out
);

  localparam int DEPTH  = IMG_W * IMG_H;
  localparam int ADDR_W = 14;
  localparam logic [ADDR_W-1:0] DEPTH_L = ADDR_W'(DEPTH);
  localparam logic [9:0] X_LO = 10'(X_OFF);
  localparam logic [9:0] X_HI = 10'(X_OFF + IMG_W - 1);
  localparam logic [8:0] Y_LO = 9'(Y_OFF);
  localparam logic [8:0] Y_HI = 9'(Y_OFF + IMG_H - 1);

  if (X_OFF + IMG_W > H_ACTIVE || Y_OFF + IMG_H > V_ACTIVE) begin : g_bad_offset
    $error("picture window does not fit in the active area");
  end

  logic [15:0] pic_mem [0:DEPTH-1];
  logic [15:0] rd_word;
  logic        win_q;
  logic        de_q;

  logic              in_win;
  logic [9:0]        rel_x;
  logic [8:0]        rel_y;
  logic [ADDR_W-1:0] rd_addr;

  assign in_win  = pix_col >= X_LO && pix_col <= X_HI &&
                   pix_row >= Y_LO && pix_row <= Y_HI;
  assign rel_x   = pix_col - X_LO;
  assign rel_y   = pix_row - Y_LO;
  assign rd_addr = ADDR_W'(int'(rel_y) * IMG_W + int'(rel_x));

  always_ff @(posedge clk) begin
    if (wr_en && wr_addr < DEPTH_L)
      pic_mem[wr_addr] <= wr_data;
    if (in_win)
      rd_word <= pic_mem[rd_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= 1'b0;
      de_q  <= 1'b0;
    end else begin
      win_q <= pix_de && in_win;
      de_q  <= pix_de;
    end
  end

  logic [4:0] r5;
  logic [5:0] g6;
  logic [4:0] b5;
  assign r5 = rd_word[15:11];
  assign g6 = rd_word[10:5];
  assign b5 = rd_word[4:0];

  assign rgb_out = !de_q ? 24'h000000 :
                   win_q ? {r5, r5[4:2], g6, g6[5:4], b5, b5[4:2]} : BG_RGB;
  assign de_out  = de_q;

  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (rgb_out == 24'h0 && !de_out)); // R1
  AST_DE_HIGH_DELAY: assert property (@(posedge clk) disable iff (!rst_n) pix_de |=> de_out); // R2
  AST_DE_LOW_DELAY: assert property (@(posedge clk) disable iff (!rst_n) !pix_de |=> !de_out); // R2
  AST_BLANK_BLACK: assert property (@(posedge clk) disable iff (!rst_n) !pix_de |=> rgb_out == 24'h0); // R3
  AST_BG_FILL: assert property (@(posedge clk) disable iff (!rst_n) (pix_de && !in_win) |=> rgb_out == BG_RGB); // R4
  AST_ADDR_BOUND: assert property (@(posedge clk) disable iff (!rst_n) in_win |-> rd_addr < DEPTH_L); // R6
  AST_EXPAND_REPL: assert property (@(posedge clk) disable iff (!rst_n) (pix_de && in_win) |=>
    (rgb_out[18:16] == rgb_out[23:21] && rgb_out[9:8] == rgb_out[15:14] && rgb_out[2:0] == rgb_out[7:5])); // R7

endmodule

// File: tb/img_window_render_tb_top.sv
module img_window_render_tb_top;

  localparam int XO = 256;
  localparam int YO = 200;
  localparam int W  = 128;
  localparam int H  = 78;
  localparam int DEPTH = W * H;
  localparam logic [23:0] BG = 24'h203040;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_de = 1'b0;
  logic [9:0]  pix_col = '0;
  logic [8:0]  pix_row = '0;
  logic        wr_en = 1'b0;
  logic [13:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [23:0] rgb_out;
  logic        de_out;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] shadow [0:DEPTH-1];

  always #4 clk = ~clk;

  img_window_render dut_i (
    .clk(clk), .rst_n(rst_n), .pix_de(pix_de), .pix_col(pix_col), .pix_row(pix_row),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rgb_out(rgb_out), .de_out(de_out)
  );

  function automatic logic [15:0] pat(int a);
    return 16'((a * 7919 + 16'h1234) ^ (a >> 3));
  endfunction

  function automatic logic [23:0] widen(logic [15:0] w);
    logic [4:0] r; logic [5:0] g; logic [4:0] b;
    r = w[15:11]; g = w[10:5]; b = w[4:0];
    return {r, r[4:2], g, g[5:4], b, b[4:2]};
  endfunction

  function automatic logic [23:0] expect_rgb(int col, int row, logic de);
    if (!de) return 24'h0;
    if (col >= XO && col < XO + W && row >= YO && row < YO + H)
      return widen(shadow[(row - YO) * W + (col - XO)]);
    return BG;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic write_word(int a, logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 14'(a); wr_data = d;
    if (a < DEPTH) shadow[a] = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic probe(string req, int col, int row, logic de);
    @(negedge clk);
    pix_col = 10'(col); pix_row = 9'(row); pix_de = de;
    @(negedge clk);
    check(req, {8'h0, rgb_out}, {8'h0, expect_rgb(col, row, de)});
    check({req, " de"}, {31'h0, de_out}, {31'h0, de});
    pix_de = 1'b0;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    pix_de = 1'b1; pix_col = 10'(XO); pix_row = 9'(YO);
    @(negedge clk);
    check("R1 rgb", {8'h0, rgb_out}, 32'h0);
    check("R1 de", {31'h0, de_out}, 32'h0);
    pix_de = 1'b0;
    rst_n = 1'b1;
  endtask

  task automatic t_fill;
    @(negedge clk);
    for (int a = 0; a < DEPTH; a++) begin
      wr_en = 1'b1; wr_addr = 14'(a); wr_data = pat(a); shadow[a] = pat(a);
      @(negedge clk);
    end
    wr_en = 1'b0;
  endtask

  task automatic t_corners;
    probe("R5 R6 top-left", XO, YO, 1'b1);
    probe("R5 R6 top-right", XO + W - 1, YO, 1'b1);
    probe("R5 R6 bottom-left", XO, YO + H - 1, 1'b1);
    probe("R5 R6 bottom-right", XO + W - 1, YO + H - 1, 1'b1);
    probe("R6 interior a", XO + 37, YO + 11, 1'b1);
    probe("R6 interior b", XO + 90, YO + 64, 1'b1);
  endtask

  task automatic t_edges;
    probe("R4 R5 left", XO - 1, YO + 5, 1'b1);
    probe("R4 R5 right", XO + W, YO + 5, 1'b1);
    probe("R4 R5 above", XO + 5, YO - 1, 1'b1);
    probe("R4 R5 below", XO + 5, YO + H, 1'b1);
    probe("R4 origin", 0, 0, 1'b1);
    probe("R4 far corner", 639, 479, 1'b1);
  endtask

  task automatic t_blank;
    probe("R3 inside window", XO + 3, YO + 3, 1'b0);
    probe("R3 outside window", 10, 10, 1'b0);
  endtask

  task automatic t_colours;
    logic [15:0] w [6] = '{16'hF800, 16'h07E0, 16'h001F, 16'h0000, 16'hFFFF, 16'h8410};
    logic [23:0] e [6] = '{24'hFF0000, 24'h00FF00, 24'h0000FF, 24'h000000, 24'hFFFFFF, 24'h848284};
    for (int i = 0; i < 6; i++) begin
      write_word(i, w[i]);
      @(negedge clk);
      pix_col = 10'(XO + i); pix_row = 9'(YO); pix_de = 1'b1;
      @(negedge clk);
      check("R7 R9 colour", {8'h0, rgb_out}, {8'h0, e[i]});
      pix_de = 1'b0;
    end
  endtask

  task automatic t_stream;
    int col;
    @(negedge clk);
    col = XO - 3;
    pix_col = 10'(col); pix_row = 9'(YO + 40); pix_de = 1'b1;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      check("R8 stream rgb", {8'h0, rgb_out}, {8'h0, expect_rgb(col, YO + 40, 1'b1)});
      check("R2 R8 stream de", {31'h0, de_out}, 32'h1);
      col = XO - 3 + k;
      pix_col = 10'(col);
      pix_de = (k != 8);
    end
    @(negedge clk);
    check("R2 de drop", {31'h0, de_out}, 32'h0);
  endtask

  task automatic t_bad_write;
    write_word(DEPTH, 16'hDEAD);
    write_word(16383, 16'hBEEF);
    probe("R10 first word kept", XO, YO, 1'b1);
    probe("R10 last word kept", XO + W - 1, YO + H - 1, 1'b1);
    write_word(DEPTH - 1, 16'h7BEF);
    probe("R9 overwrite last", XO + W - 1, YO + H - 1, 1'b1);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_fill();
    t_corners();
    t_edges();
    t_blank();
    t_colours();
    t_stream();
    t_bad_write();
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule